// File: doc/BRIEF.md
# Latency-Table Decode Interlock

This block sits at the decode stage of an in-order, single-issue pipeline. Each cycle it receives one decoded descriptor and decides whether that instruction may issue or must wait. The descriptor gives a valid bit, a class code, a destination register and up to two source registers. Each register carries a file tag that selects the integer file or the floating-point file. When the instruction must wait, the block raises `stall_o`. The upstream stage then holds the descriptor, and the cycle becomes a bubble. When the instruction may go, the block raises `issue_o`.

The wait does not come from a single forwarding rule. It comes from a table indexed by the producer's class and the consumer's class. An FP operation therefore waits longer for an FP result than a store does for the same value. A store uses the store column of the table for all of its sources.

The block keeps a short history of in-flight producers. Each entry holds the destination register, its file tag, the producer class and a countdown. The countdown is loaded when the producer issues and drops by one every cycle, whether or not the pipeline is stalled. A producer whose latencies are all zero takes no history slot.

Top module: `ilk_interlock`

## Requirements
- R1: While reset is asserted, and after reset is released, the history is empty. An instruction presented first after reset, or after a reset that arrives while entries are live, issues with no stall.
- R2: `issue_o` is `valid_i` and not `stall_o`. With `valid_i` low, both outputs are low. Class codes on `cls_i` are:
  - 0: integer operation
  - 1: branch
  - 2: load double
  - 3: store double
  - 4: FP ALU operation
  - 5: no-op
- R3: An FP ALU operation that reads the result of the FP ALU operation just before it stalls for exactly 3 cycles.
- R4: A store whose data source (`src_b`, FP tag) is the result of the FP ALU operation just before it stalls for exactly 2 cycles.
- R5: An FP ALU operation that reads the result of the load just before it stalls for exactly 1 cycle.
- R6: A store whose data is the result of the load just before it issues with no stall.
- R7: An integer operation or branch that reads the integer result of the integer operation just before it issues with no stall.
- R8: A dependence exists only when both the register number and the file tag match. Integer register 0 never forms a dependence. FP register 0 is an ordinary register.
- R9: Countdowns keep running while the pipeline is stalled, and a stalled instruction adds no history entry. Several producers can be in flight at once, and the consumer waits for the latest of its matching constraints.
- R10: When a newer instruction writes a register that has an older write still in flight, the older entry is dropped. Consumers then wait only on the newer producer's latency.
- R11: The loop body load, dependent FP add, dependent store, integer decrement, branch and no-op delay slot takes 9 cycles per iteration: 1 stall after the load and 2 stalls after the add.
- R12: A no-op never stalls and never creates an entry, whatever its register fields hold. An invalid descriptor likewise creates no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Decode descriptor is valid |
| cls_i | input | 3 | Instruction class code |
| dst_en_i | input | 1 | Destination register is written |
| dst_fp_i | input | 1 | Destination file tag (1 = FP) |
| dst_idx_i | input | REG_W | Destination register number |
| src_a_en_i | input | 1 | Source A is read |
| src_a_fp_i | input | 1 | Source A file tag |
| src_a_idx_i | input | REG_W | Source A register number |
| src_b_en_i | input | 1 | Source B is read |
| src_b_fp_i | input | 1 | Source B file tag |
| src_b_idx_i | input | REG_W | Source B register number |
| stall_o | output | 1 | Hold the decode instruction and insert a bubble |
| issue_o | output | 1 | Decode instruction issues this cycle |

## Verification
Two functions can fall in the same cycle. In that cycle a newer producer both takes a history slot and drops an older in-flight write to the same register, while a slot whose countdown is about to expire is being reused. The bench provokes this with directed back-to-back rewrites of one register, then with long random streams over only four register numbers. A per-register model records the cycle and class of the last write and computes each expected stall from the number of intervening cycles. Every cycle, that model judges both outputs.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    CLS_INT  = 3'd0,
    CLS_BR   = 3'd1,
    CLS_LD   = 3'd2,
    CLS_ST   = 3'd3,
    CLS_FP   = 3'd4,
    CLS_NOP  = 3'd5,
    CLS_RSV6 = 3'd6,
    CLS_RSV7 = 3'd7
  } cls_e;

  function automatic logic cls_writes(cls_e c);
    return (c == CLS_INT) || (c == CLS_LD) || (c == CLS_FP);
  endfunction

  function automatic logic cls_reads(cls_e c);
    return (c == CLS_INT) || (c == CLS_BR) || (c == CLS_LD) ||
           (c == CLS_ST) || (c == CLS_FP);
  endfunction

endpackage

// File: rtl/ilk_lat_table.sv
module ilk_lat_table
  import ilk_pkg::*;
#(
  parameter int LAT_FP_FP   = 3,
  parameter int LAT_FP_ST   = 2,
  parameter int LAT_LD_FP   = 1,
  parameter int LAT_LD_ST   = 0,
  parameter int LAT_INT_INT = 0,
  parameter int CNT_W       = 2
) (
  input  cls_e             prod_i,
  output logic [CNT_W-1:0] need_fp_o,
  output logic [CNT_W-1:0] need_st_o
);

  // fp column: any non-store consumer; st column: store consumer
  always_comb begin
    case (prod_i)
      CLS_FP: begin
        need_fp_o = CNT_W'(LAT_FP_FP);
        need_st_o = CNT_W'(LAT_FP_ST);
      end
      CLS_LD: begin
        need_fp_o = CNT_W'(LAT_LD_FP);
        need_st_o = CNT_W'(LAT_LD_ST);
      end
      CLS_INT: begin
        need_fp_o = CNT_W'(LAT_INT_INT);
        need_st_o = CNT_W'(LAT_INT_INT);
      end
      default: begin
        need_fp_o = '0;
        need_st_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/ilk_alloc.sv
module ilk_alloc #(
  parameter int DEPTH = 3
) (
  input  logic             req_i,
  input  logic [DEPTH-1:0] free_i,
  output logic [DEPTH-1:0] grant_o,
  output logic             room_o
);

  assign room_o = |free_i;

  // lowest free slot wins
  for (genvar i = 0; i < DEPTH; i++) begin : g_pick
    if (i == 0) begin : g_first
      assign grant_o[i] = req_i & free_i[i];
    end else begin : g_rest
      assign grant_o[i] = req_i & free_i[i] & ~(|free_i[i-1:0]);
    end
  end

endmodule

// File: rtl/ilk_hist_entry.sv
module ilk_hist_entry
  import ilk_pkg::*;
#(
  parameter int LAT_FP_FP   = 3,
  parameter int LAT_FP_ST   = 2,
  parameter int LAT_LD_FP   = 1,
  parameter int LAT_LD_ST   = 0,
  parameter int LAT_INT_INT = 0,
  parameter int REG_W       = 5,
  parameter int CNT_W       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             kill_i,
  input  cls_e             new_cls_i,
  input  logic             new_fp_i,
  input  logic [REG_W-1:0] new_idx_i,
  input  logic [CNT_W-1:0] new_cnt_i,
  input  logic             qa_en_i,
  input  logic             qa_fp_i,
  input  logic [REG_W-1:0] qa_idx_i,
  input  logic             qb_en_i,
  input  logic             qb_fp_i,
  input  logic [REG_W-1:0] qb_idx_i,
  input  logic             q_st_i,
  output logic             hit_o,
  output logic             free_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  cls_e             cls_q;
  logic             fp_q;
  logic [REG_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;

  logic [CNT_W-1:0] need_fp, need_st, need, span;
  logic             live, match_a, match_b, same_dst;

  ilk_lat_table #(
    .LAT_FP_FP  (LAT_FP_FP),
    .LAT_FP_ST  (LAT_FP_ST),
    .LAT_LD_FP  (LAT_LD_FP),
    .LAT_LD_ST  (LAT_LD_ST),
    .LAT_INT_INT(LAT_INT_INT),
    .CNT_W      (CNT_W)
  ) u_tab (
    .prod_i   (cls_q),
    .need_fp_o(need_fp),
    .need_st_o(need_st)
  );

  assign need     = q_st_i ? need_st : need_fp;
  assign span     = (need_fp > need_st) ? need_fp : need_st;
  assign live     = (cnt_q != '0);
  assign match_a  = qa_en_i && (qa_fp_i == fp_q) && (qa_idx_i == idx_q);
  assign match_b  = qb_en_i && (qb_fp_i == fp_q) && (qb_idx_i == idx_q);
  assign same_dst = kill_i && (new_fp_i == fp_q) && (new_idx_i == idx_q);

  // counter starts at the producer's longest wait; slack = span - need
  assign hit_o  = live && (match_a || match_b) &&
                  (({1'b0, cnt_q} + {1'b0, need}) > {1'b0, span});
  // reusable at the coming edge
  assign free_o = (cnt_q <= ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q <= CLS_NOP;
      fp_q  <= 1'b0;
      idx_q <= '0;
      cnt_q <= '0;
    end else if (alloc_i) begin
      cls_q <= new_cls_i;
      fp_q  <= new_fp_i;
      idx_q <= new_idx_i;
      cnt_q <= new_cnt_i;
    end else if (same_dst) begin
      cnt_q <= '0;
    end else if (live) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  p_cnt_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= span);

  p_countdown_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !alloc_i && !same_dst) |=> (cnt_q == $past(cnt_q) - ONE));

  p_waw_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same_dst && !alloc_i) |=> (cnt_q == '0));

  p_no_int_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live |-> (fp_q || (idx_q != '0)));

endmodule

// File: rtl/ilk_interlock.sv
module ilk_interlock
  import ilk_pkg::*;
#(
  parameter int NUM_REGS    = 32,
  parameter int HIST_DEPTH  = 3,
  parameter int LAT_FP_FP   = 3,
  parameter int LAT_FP_ST   = 2,
  parameter int LAT_LD_FP   = 1,
  parameter int LAT_LD_ST   = 0,
  parameter int LAT_INT_INT = 0,
  localparam int REG_W      = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       cls_i,
  input  logic             dst_en_i,
  input  logic             dst_fp_i,
  input  logic [REG_W-1:0] dst_idx_i,
  input  logic             src_a_en_i,
  input  logic             src_a_fp_i,
  input  logic [REG_W-1:0] src_a_idx_i,
  input  logic             src_b_en_i,
  input  logic             src_b_fp_i,
  input  logic [REG_W-1:0] src_b_idx_i,
  output logic             stall_o,
  output logic             issue_o
);

  localparam int M1      = (LAT_FP_FP > LAT_FP_ST) ? LAT_FP_FP : LAT_FP_ST;
  localparam int M2      = (LAT_LD_FP > LAT_LD_ST) ? LAT_LD_FP : LAT_LD_ST;
  localparam int M3      = (M1 > M2) ? M1 : M2;
  localparam int MAX_LAT = (M3 > LAT_INT_INT) ? M3 : LAT_INT_INT;
  localparam int CNT_W   = (MAX_LAT < 1) ? 1 : $clog2(MAX_LAT + 1);

  cls_e cls;
  assign cls = cls_e'(cls_i);

  logic use_a, use_b, cons_st, hazard, wr, alloc_req, room;
  logic [CNT_W-1:0] new_fp, new_st, new_span;
  logic [HIST_DEPTH-1:0] hit, free, grant;

  // int r0 is never a dependence
  assign use_a   = cls_reads(cls) && src_a_en_i && (src_a_fp_i || (src_a_idx_i != '0));
  assign use_b   = cls_reads(cls) && src_b_en_i && (src_b_fp_i || (src_b_idx_i != '0));
  assign cons_st = (cls == CLS_ST);

  assign hazard  = |hit;
  assign stall_o = valid_i && hazard;
  assign issue_o = valid_i && !hazard;

  ilk_lat_table #(
    .LAT_FP_FP  (LAT_FP_FP),
    .LAT_FP_ST  (LAT_FP_ST),
    .LAT_LD_FP  (LAT_LD_FP),
    .LAT_LD_ST  (LAT_LD_ST),
    .LAT_INT_INT(LAT_INT_INT),
    .CNT_W      (CNT_W)
  ) u_new_tab (
    .prod_i   (cls),
    .need_fp_o(new_fp),
    .need_st_o(new_st)
  );

  assign new_span  = (new_fp > new_st) ? new_fp : new_st;
  assign wr        = issue_o && cls_writes(cls) && dst_en_i &&
                     (dst_fp_i || (dst_idx_i != '0));
  assign alloc_req = wr && (new_span != '0);

  ilk_alloc #(
    .DEPTH(HIST_DEPTH)
  ) u_alloc (
    .req_i  (alloc_req),
    .free_i (free),
    .grant_o(grant),
    .room_o (room)
  );

  for (genvar i = 0; i < HIST_DEPTH; i++) begin : g_hist
    ilk_hist_entry #(
      .LAT_FP_FP  (LAT_FP_FP),
      .LAT_FP_ST  (LAT_FP_ST),
      .LAT_LD_FP  (LAT_LD_FP),
      .LAT_LD_ST  (LAT_LD_ST),
      .LAT_INT_INT(LAT_INT_INT),
      .REG_W      (REG_W),
      .CNT_W      (CNT_W)
    ) u_ent (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .alloc_i  (grant[i]),
      .kill_i   (wr),
      .new_cls_i(cls),
      .new_fp_i (dst_fp_i),
      .new_idx_i(dst_idx_i),
      .new_cnt_i(new_span),
      .qa_en_i  (use_a),
      .qa_fp_i  (src_a_fp_i),
      .qa_idx_i (src_a_idx_i),
      .qb_en_i  (use_b),
      .qb_fp_i  (src_b_fp_i),
      .qb_idx_i (src_b_idx_i),
      .q_st_i   (cons_st),
      .hit_o    (hit[i]),
      .free_o   (free[i])
    );
  end

  p_alloc_room_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_req |-> room);

  p_nop_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (cls == CLS_NOP)) |-> !stall_o);

  p_single_grant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

endmodule

// File: tb/tb_ilk_interlock.sv
module tb_ilk_interlock;

  localparam int RW = 5;

  typedef struct packed {
    logic          v;
    logic [2:0]    c;
    logic          de;
    logic          df;
    logic [RW-1:0] di;
    logic          ae;
    logic          af;
    logic [RW-1:0] ai;
    logic          be;
    logic          bf;
    logic [RW-1:0] bi;
  } desc_t;

  logic  clk = 1'b0;
  logic  rst_n = 1'b0;
  desc_t cur;
  logic  stall, issue;

  always #5 clk = ~clk;

  ilk_interlock dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .valid_i    (cur.v),
    .cls_i      (cur.c),
    .dst_en_i   (cur.de),
    .dst_fp_i   (cur.df),
    .dst_idx_i  (cur.di),
    .src_a_en_i (cur.ae),
    .src_a_fp_i (cur.af),
    .src_a_idx_i(cur.ai),
    .src_b_en_i (cur.be),
    .src_b_fp_i (cur.bf),
    .src_b_idx_i(cur.bi),
    .stall_o    (stall),
    .issue_o    (issue)
  );

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done_f = 0;
  bit has[64];
  int last_cyc[64];
  int last_cls[64];

  task automatic check(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // required intervening cycles, from the requirements
  function automatic int need(int prod, bit st);
    case (prod)
      2:       return st ? 0 : 1;
      4:       return st ? 2 : 3;
      default: return 0;
    endcase
  endfunction

  function automatic bit src_hit(logic en, logic fp, logic [RW-1:0] idx, bit st);
    int k;
    if (!en) return 0;
    if (!fp && idx == 0) return 0;
    k = int'({fp, idx});
    if (!has[k]) return 0;
    return (cyc - last_cyc[k] - 1) < need(last_cls[k], st);
  endfunction

  function automatic bit exp_stall(desc_t d);
    bit st;
    if (!d.v || d.c > 3'd4) return 0;
    st = (d.c == 3'd3);
    return src_hit(d.ae, d.af, d.ai, st) || src_hit(d.be, d.bf, d.bi, st);
  endfunction

  function automatic void record(desc_t d);
    int k;
    if ((d.c == 3'd0 || d.c == 3'd2 || d.c == 3'd4) && d.de && (d.df || d.di != 0)) begin
      k = int'({d.df, d.di});
      has[k] = 1;
      last_cyc[k] = cyc;
      last_cls[k] = int'(d.c);
    end
  endfunction

  function automatic desc_t d_fp(int dst, int a, int b);
    desc_t d = '0;
    d.v = 1; d.c = 3'd4; d.de = 1; d.df = 1; d.di = RW'(dst);
    d.ae = 1; d.af = 1; d.ai = RW'(a); d.be = 1; d.bf = 1; d.bi = RW'(b);
    return d;
  endfunction

  function automatic desc_t d_ld(int dst, int base);
    desc_t d = '0;
    d.v = 1; d.c = 3'd2; d.de = 1; d.df = 1; d.di = RW'(dst);
    d.ae = 1; d.ai = RW'(base);
    return d;
  endfunction

  function automatic desc_t d_st(int base, int data);
    desc_t d = '0;
    d.v = 1; d.c = 3'd3;
    d.ae = 1; d.ai = RW'(base); d.be = 1; d.bf = 1; d.bi = RW'(data);
    return d;
  endfunction

  function automatic desc_t d_int(int dst, int a);
    desc_t d = '0;
    d.v = 1; d.c = 3'd0; d.de = 1; d.di = RW'(dst);
    d.ae = 1; d.ai = RW'(a);
    return d;
  endfunction

  function automatic desc_t d_br(int a);
    desc_t d = '0;
    d.v = 1; d.c = 3'd1; d.ae = 1; d.ai = RW'(a);
    return d;
  endfunction

  function automatic desc_t d_nop();
    desc_t d = '0;
    d.v = 1; d.c = 3'd5;
    return d;
  endfunction

  function automatic desc_t rnd();
    desc_t d;
    int r = int'($urandom_range(0, 9));
    int x = int'($urandom_range(0, 3));
    int y = int'($urandom_range(0, 3));
    int z = int'($urandom_range(0, 3));
    case (r)
      0, 1: d = d_int(x, y);
      2:    d = d_br(x);
      3, 4: d = d_ld(x, y);
      5:    d = d_st(x, y);
      6, 7: d = d_fp(x, y, z);
      8: begin
        d = desc_t'(25'($urandom));
        d.v = 1; d.c = 3'd5;
      end
      default: begin
        d = desc_t'(25'($urandom));
        d.v = 0;
      end
    endcase
    return d;
  endfunction

  // present d until it issues; one output check per cycle
  task automatic step(input string tag, input desc_t d, output int stalls);
    bit es, ei, fin;
    stalls = 0;
    fin = 0;
    while (!fin) begin
      @(negedge clk);
      cur = d;
      #1;
      es = exp_stall(d);
      ei = d.v && !es;
      check(tag, int'({stall, issue}), int'({es, ei}));
      @(posedge clk);
      if (ei) record(d);
      cyc++;
      if (es) stalls++;
      else fin = 1;
      if (stalls > 8) begin
        check({tag, " runaway stall"}, stalls, 8);
        fin = 1;
      end
    end
  endtask

  task automatic idle(input int n);
    int s;
    desc_t d = '0;
    for (int i = 0; i < n; i++) step("R2 idle", d, s);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    cur = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 64; i++) has[i] = 0;
  endtask

  task automatic summary();
    done_f = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #2000000;
    if (!done_f) begin
      n_run++;
      n_fail++;
      $display("FAIL R9 watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int s, tot;
    desc_t d;
    cur = '0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) has[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur = d_fp(1, 1, 1);
    #1;
    check("R1 outputs in reset", int'({stall, issue}), 1);
    @(negedge clk);
    rst_n = 1;
    cur = '0;

    step("R1", d_fp(2, 1, 1), s);   check("R1 first after reset", s, 0);
    idle(4);

    step("R3", d_fp(1, 2, 2), s);
    step("R3", d_fp(5, 1, 2), s);   check("R3 fp->fp stalls", s, 3);
    idle(4);
    step("R4", d_fp(1, 2, 2), s);
    step("R4", d_st(2, 1), s);      check("R4 fp->store stalls", s, 2);
    idle(4);
    step("R5", d_ld(6, 1), s);
    step("R5", d_fp(7, 6, 6), s);   check("R5 load->fp stalls", s, 1);
    idle(4);
    step("R6", d_ld(6, 1), s);
    step("R6", d_st(1, 6), s);      check("R6 load->store stalls", s, 0);
    idle(4);
    step("R7", d_int(5, 1), s);
    step("R7", d_int(6, 5), s);     check("R7 int->int stalls", s, 0);
    step("R7", d_br(6), s);         check("R7 int->branch stalls", s, 0);
    idle(4);

    step("R8", d_fp(3, 2, 2), s);
    step("R8", d_int(4, 3), s);     check("R8 tag mismatch stalls", s, 0);
    idle(4);
    step("R8", d_fp(0, 2, 2), s);
    step("R8", d_fp(8, 0, 0), s);   check("R8 fp reg0 stalls", s, 3);
    idle(4);

    step("R9", d_fp(1, 2, 2), s);
    step("R9", d_fp(2, 3, 3), s);   check("R9 independent", s, 0);
    step("R9", d_fp(9, 1, 2), s);   check("R9 latest of two", s, 3);
    step("R9", d_fp(10, 9, 9), s);  check("R9 stalled op no early entry", s, 3);
    idle(4);

    step("R10", d_fp(1, 2, 2), s);
    step("R10", d_ld(1, 3), s);     check("R10 rewrite issues", s, 0);
    step("R10", d_fp(5, 1, 1), s);  check("R10 newer latency only", s, 1);
    idle(4);

    for (int it = 0; it < 2; it++) begin
      tot = 0;
      step("R11", d_ld(0, 1), s);     tot += s + 1;
      step("R11", d_fp(4, 0, 2), s);  tot += s + 1; check("R11 stall after load", s, 1);
      step("R11", d_st(1, 4), s);     tot += s + 1; check("R11 stalls after add", s, 2);
      step("R11", d_int(1, 1), s);    tot += s + 1;
      step("R11", d_br(1), s);        tot += s + 1;
      step("R11", d_nop(), s);        tot += s + 1;
      check("R11 cycles per iteration", tot, 9);
    end
    idle(4);

    step("R12", d_fp(1, 2, 2), s);
    d = d_nop(); d.ae = 1; d.af = 1; d.ai = 1; d.be = 1; d.bf = 1; d.bi = 1;
    step("R12", d, s);              check("R12 nop reading live reg", s, 0);
    idle(4);
    d = d_nop(); d.de = 1; d.df = 1; d.di = 7;
    step("R12", d, s);
    step("R12", d_fp(8, 7, 7), s);  check("R12 nop leaves no entry", s, 0);
    idle(4);
    d = d_fp(7, 2, 2); d.v = 0;
    step("R12", d, s);
    step("R12", d_fp(8, 7, 7), s);  check("R12 invalid leaves no entry", s, 0);
    idle(4);

    step("R1", d_fp(1, 2, 2), s);
    do_reset();
    step("R1", d_fp(5, 1, 1), s);   check("R1 reset clears live entry", s, 0);

    for (int i = 0; i < 800; i++) step("R9 random", rnd(), s);
    idle(2);

    summary();
    $finish;
  end

endmodule